// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block collects level-sensitive interrupt request lines, holds each one in a pending register, and offers the highest-ranked eligible line to the processor core. The offer is a single request signal with a level number. The level number tells the core which handler to start. The block keeps a mask of the levels whose handlers are running on the core. A pending line is eligible only when its level is strictly above the highest level in that mask. As a result, a handler can be preempted only by a more urgent one, and a level is never entered again while it is still in service.

The core takes an offer with a one-cycle acknowledge pulse. When a handler returns, the core sends a one-cycle completion pulse, and the block retires the highest running level. Lower-ranked requests that were held back then become eligible again. Some levels have no handler installed. In that case the core raises acknowledge and completion in the same cycle. The block then drops the pending bit without ever counting that level as running.

Top module: `prio_nest_intc`

## Requirements
- R1: While reset is asserted, and after it is released, the request output is 0, the level output is 0, and no line is pending or in service.
- R2: A line seen high at a rising clock edge is held pending until its level is acknowledged, even if the line later falls. It is offered to the core no earlier than the second edge after it was first seen.
- R3: Lines have fixed priority, with index NUM_LINES-1 the highest. Among the eligible pending lines, the one with the largest index is offered.
- R4: Once the request output is high, it stays high with an unchanged level until acknowledge, even if a higher-ranked line becomes pending.
- R5: Acknowledge while a request is high clears that level's pending bit, marks the level in service, and drops the request on the next cycle.
- R6: A pending level is offered only when it is strictly greater than the highest in-service level. A level equal to or below it, including the in-service level itself, stays pending and is not offered.
- R7: A completion pulse (without acknowledge) retires the highest in-service level. On the following cycle the highest pending line that has become eligible is offered.
- R8: A completion pulse while no level is in service changes nothing.
- R9: Acknowledge and completion in the same cycle mean the offered level has no handler. The pending bit is cleared and the level is not marked in service.
- R10: Acknowledge while no request is high is ignored, and pending state is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_lines | input | NUM_LINES | Level-sensitive interrupt request lines |
| core_req | output | 1 | Interrupt offered to the core |
| core_lvl | output | LVL_W | Level of the offered interrupt |
| core_ack | input | 1 | Core takes the offered interrupt (one-cycle pulse) |
| core_done | input | 1 | Handler return, or null handler when raised together with acknowledge |

## Verification
The stimulus covers several patterns:
- A single line pulsed for one cycle, which separates latching from mere sampling.
- Several lines raised at once, which shows whether arbitration picks the largest index.
- A higher line raised while a lower offer is waiting, which distinguishes a stable handshake from one that switches its level.
- Nested handlers at levels 3, 7 and 5 with completions in between, which show that the threshold follows the highest running level and drops back after each return.

Same-level re-assertion, acknowledge together with completion, a completion with an empty mask, and an acknowledge with no offer each produce a different next offer depending on whether the in-service mask was changed. That next offer is what the bench observes.

// File: rtl/prio_intc_pkg.sv
`timescale 1ns/1ps
package prio_intc_pkg;
   // Width of a level index for n lines (at least one bit).
   function automatic int unsigned lvl_width(int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/intc_prio_pick.sv
`timescale 1ns/1ps
module intc_prio_pick #(
   parameter int unsigned NUM_LINES = 8,
   localparam int unsigned LVL_W = prio_intc_pkg::lvl_width(NUM_LINES)
) (
   input  logic [NUM_LINES-1:0] vec,
   output logic                 any,
   output logic [LVL_W-1:0]     idx
);
   // The highest set bit wins: the scan runs upward, so later hits overwrite earlier ones.
   always_comb begin
      any = 1'b0;
      idx = '0;
      for (int i = 0; i < NUM_LINES; i++) begin
         if (vec[i]) begin
            any = 1'b1;
            idx = LVL_W'(i);
         end
      end
   end
endmodule

// File: rtl/intc_pend_latch.sv
`timescale 1ns/1ps
module intc_pend_latch #(
   parameter int unsigned NUM_LINES = 8,
   localparam int unsigned LVL_W = prio_intc_pkg::lvl_width(NUM_LINES)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] lines,
   input  logic                 clr_en,
   input  logic [LVL_W-1:0]     clr_lvl,
   output logic [NUM_LINES-1:0] pend
);
   for (genvar g = 0; g < NUM_LINES; g++) begin : g_bit
      logic hit;
      // Clearing takes priority over a line that is still high in the same cycle.
      assign hit = clr_en && (clr_lvl == LVL_W'(g));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   pend[g] <= 1'b0;
         else if (hit) pend[g] <= 1'b0;
         else          pend[g] <= pend[g] | lines[g];
      end
   end
endmodule

// File: rtl/intc_svc_track.sv
`timescale 1ns/1ps
module intc_svc_track #(
   parameter int unsigned NUM_LINES = 8,
   localparam int unsigned LVL_W = prio_intc_pkg::lvl_width(NUM_LINES)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 enter,
   input  logic [LVL_W-1:0]     enter_lvl,
   input  logic                 retire,
   output logic [NUM_LINES-1:0] mask,
   output logic                 busy,
   output logic [LVL_W-1:0]     top
);
   logic [NUM_LINES-1:0] mask_nx;

   intc_prio_pick #(.NUM_LINES(NUM_LINES)) u_top (
      .vec (mask),
      .any (busy),
      .idx (top)
   );

   always_comb begin
      mask_nx = mask;
      if (enter)
         mask_nx[enter_lvl] = 1'b1;
      else if (retire && busy)
         mask_nx[top] = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mask <= '0;
      else        mask <= mask_nx;
   end
endmodule

// File: rtl/prio_nest_intc.sv
`timescale 1ns/1ps
module prio_nest_intc #(
   parameter int unsigned NUM_LINES = 8,
   localparam int unsigned LVL_W = prio_intc_pkg::lvl_width(NUM_LINES)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] irq_lines,
   output logic                 core_req,
   output logic [LVL_W-1:0]     core_lvl,
   input  logic                 core_ack,
   input  logic                 core_done
);
   if (NUM_LINES < 2 || NUM_LINES > 64) begin : g_bad_lines
      $error("prio_nest_intc: NUM_LINES must lie in 2..64");
   end

   logic                 req_q;
   logic [LVL_W-1:0]     lvl_q;
   logic [NUM_LINES-1:0] pend_q;
   logic [NUM_LINES-1:0] svc_mask;
   logic                 svc_busy;
   logic [LVL_W-1:0]     svc_top;
   logic [NUM_LINES-1:0] above;
   logic                 cand_any;
   logic [LVL_W-1:0]     cand_lvl;
   logic                 take;
   logic                 take_real;
   logic                 retire;

   // Handshake decode.
   assign take      = req_q && core_ack;
   assign take_real = take && !core_done;
   assign retire    = core_done && !take;

   intc_pend_latch #(.NUM_LINES(NUM_LINES)) u_pend (
      .clk     (clk),
      .rst_n   (rst_n),
      .lines   (irq_lines),
      .clr_en  (take),
      .clr_lvl (lvl_q),
      .pend    (pend_q)
   );

   intc_svc_track #(.NUM_LINES(NUM_LINES)) u_svc (
      .clk       (clk),
      .rst_n     (rst_n),
      .enter     (take_real),
      .enter_lvl (lvl_q),
      .retire    (retire),
      .mask      (svc_mask),
      .busy      (svc_busy),
      .top       (svc_top)
   );

   // Eligibility window: strictly above the highest running level.
   for (genvar g = 0; g < NUM_LINES; g++) begin : g_above
      assign above[g] = !svc_busy || (LVL_W'(g) > svc_top);
   end

   intc_prio_pick #(.NUM_LINES(NUM_LINES)) u_cand (
      .vec (pend_q & above),
      .any (cand_any),
      .idx (cand_lvl)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q <= 1'b0;
         lvl_q <= '0;
      end else if (take) begin
         req_q <= 1'b0;
      end else if (!req_q && cand_any) begin
         req_q <= 1'b1;
         lvl_q <= cand_lvl;
      end
   end

   assign core_req = req_q;
   assign core_lvl = lvl_q;
endmodule

// File: rtl/intc_checker.sv
`timescale 1ns/1ps
module intc_checker #(
   parameter int unsigned NUM_LINES = 8,
   localparam int unsigned LVL_W = prio_intc_pkg::lvl_width(NUM_LINES)
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 core_req,
   input logic [LVL_W-1:0]     core_lvl,
   input logic                 core_ack,
   input logic                 core_done,
   input logic [NUM_LINES-1:0] isr_mask,
   input logic [NUM_LINES-1:0] pend_mask
);
   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      core_req && !core_ack |=> core_req && $stable(core_lvl)); // R4

   AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      core_req && core_ack |=> !core_req); // R5

   AST_ACK_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
      core_req && core_ack && !core_done |=> isr_mask[$past(core_lvl)]); // R5

   AST_OFFER_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
      core_req |-> ((isr_mask >> core_lvl) == '0)); // R6

   AST_OFFER_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      core_req |-> pend_mask[core_lvl]); // R2

   AST_IDLE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (isr_mask == '0) && core_done |=> (isr_mask == '0)); // R8

   AST_NULL_HANDLER: assert property (@(posedge clk) disable iff (!rst_n)
      core_req && core_ack && core_done |=> $stable(isr_mask)); // R9
endmodule

bind prio_nest_intc intc_checker #(.NUM_LINES(NUM_LINES)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .core_req  (core_req),
   .core_lvl  (core_lvl),
   .core_ack  (core_ack),
   .core_done (core_done),
   .isr_mask  (svc_mask),
   .pend_mask (pend_q)
);

// File: tb/tb_prio_nest_intc.sv
`timescale 1ns/1ps
module tb_prio_nest_intc;
   localparam int unsigned N = 8;
   localparam int unsigned LW = 3;
   localparam int unsigned NV = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  lines = '0;
   logic          ack = 1'b0;
   logic          done = 1'b0;
   logic          req;
   logic [LW-1:0] lvl;
   int            checks = 0;
   int            fails = 0;

   always #2.5 clk = ~clk;

   prio_nest_intc #(.NUM_LINES(N)) dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .irq_lines (lines),
      .core_req  (req),
      .core_lvl  (lvl),
      .core_ack  (ack),
      .core_done (done)
   );

   // Row layout: [17:14] requirement, [13:6] lines, [5] ack, [4] done, [3] exp req, [2:0] exp level.
   // Inputs are applied before an edge; expected outputs hold after that edge.
   localparam logic [17:0] VEC [NV] = '{
      {4'd2, 8'h08, 1'b0, 1'b0, 1'b0, 3'd0},  // R2 line 3 pulsed
      {4'd2, 8'h00, 1'b0, 1'b0, 1'b1, 3'd3},  // R2 still offered after drop
      {4'd4, 8'h80, 1'b0, 1'b0, 1'b1, 3'd3},  // R4 higher arrives, offer held
      {4'd5, 8'h00, 1'b1, 1'b0, 1'b0, 3'd0},  // R5 take 3
      {4'd6, 8'h00, 1'b0, 1'b0, 1'b1, 3'd7},  // R6 7 preempts 3
      {4'd5, 8'h00, 1'b1, 1'b0, 1'b0, 3'd0},  // R5 take 7
      {4'd6, 8'h20, 1'b0, 1'b0, 1'b0, 3'd0},  // R6 line 5 below 7
      {4'd6, 8'h00, 1'b0, 1'b0, 1'b0, 3'd0},  // R6 still held back
      {4'd7, 8'h00, 1'b0, 1'b1, 1'b0, 3'd0},  // R7 retire 7
      {4'd7, 8'h00, 1'b0, 1'b0, 1'b1, 3'd5},  // R7 5 released
      {4'd5, 8'h00, 1'b1, 1'b0, 1'b0, 3'd0},  // R5 take 5
      {4'd7, 8'h00, 1'b0, 1'b1, 1'b0, 3'd0},  // R7 retire 5
      {4'd7, 8'h00, 1'b0, 1'b1, 1'b0, 3'd0},  // R7 retire 3
      {4'd8, 8'h00, 1'b0, 1'b1, 1'b0, 3'd0},  // R8 done on empty mask
      {4'd3, 8'h02, 1'b0, 1'b0, 1'b0, 3'd0},  // R3 line 1
      {4'd3, 8'h00, 1'b0, 1'b0, 1'b1, 3'd1},  // R3 offered, nothing running
      {4'd9, 8'h00, 1'b1, 1'b1, 1'b0, 3'd0},  // R9 null handler
      {4'd9, 8'h01, 1'b0, 1'b0, 1'b0, 3'd0},  // R9 line 0
      {4'd9, 8'h00, 1'b0, 1'b0, 1'b1, 3'd0},  // R9 0 offered: 1 not in service
      {4'd5, 8'h00, 1'b1, 1'b0, 1'b0, 3'd0},  // R5 take 0
      {4'd6, 8'h01, 1'b0, 1'b0, 1'b0, 3'd0},  // R6 same level re-raised
      {4'd6, 8'h01, 1'b0, 1'b0, 1'b0, 3'd0},  // R6 no re-entry
      {4'd7, 8'h00, 1'b0, 1'b1, 1'b0, 3'd0},  // R7 retire 0
      {4'd7, 8'h00, 1'b0, 1'b0, 1'b1, 3'd0},  // R7 0 offered again
      {4'd5, 8'h00, 1'b1, 1'b0, 1'b0, 3'd0},  // R5 take 0
      {4'd7, 8'h00, 1'b0, 1'b1, 1'b0, 3'd0},  // R7 retire 0
      {4'd3, 8'h66, 1'b0, 1'b0, 1'b0, 3'd0},  // R3 lines 1,2,5,6
      {4'd3, 8'h00, 1'b0, 1'b0, 1'b1, 3'd6},  // R3 largest wins
      {4'd5, 8'h00, 1'b1, 1'b0, 1'b0, 3'd0},  // R5 take 6
      {4'd6, 8'h00, 1'b0, 1'b0, 1'b0, 3'd0},  // R6 1,2,5 below 6
      {4'd7, 8'h00, 1'b0, 1'b1, 1'b0, 3'd0},  // R7 retire 6
      {4'd3, 8'h00, 1'b0, 1'b0, 1'b1, 3'd5}   // R3 next largest
   };

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic check_out(input int rq, input string what, input logic exp_req,
                            input logic [LW-1:0] exp_lvl, input logic chk_lvl);
      checks++;
      if (req !== exp_req || (chk_lvl && lvl !== exp_lvl)) begin
         fails++;
         $display("FAIL R%0d %s: actual req=%0b lvl=%0d expected req=%0b lvl=%0d",
                  rq, what, req, lvl, exp_req, exp_lvl);
      end
   endtask

   initial begin
      #100000;
      fails++;
      $display("FAIL R1 watchdog: actual=timeout expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      // R1: outputs quiet during reset.
      @(negedge clk);
      @(negedge clk);
      check_out(1, "in reset", 1'b0, '0, 1'b1);
      rst_n = 1'b1;
      step();
      step();
      check_out(1, "after release", 1'b0, '0, 1'b1);

      for (int i = 0; i < NV; i++) begin
         lines = VEC[i][13:6];
         ack   = VEC[i][5];
         done  = VEC[i][4];
         step();
         check_out(int'(VEC[i][17:14]), $sformatf("row %0d", i),
                   VEC[i][3], VEC[i][2:0], VEC[i][3]);
      end
      lines = '0; ack = 1'b0; done = 1'b0;

      // R1: reset while an offer is up clears it and all pending state.
      rst_n = 1'b0;
      @(negedge clk);
      check_out(1, "reset mid offer", 1'b0, '0, 1'b1);
      rst_n = 1'b1;
      step();
      step();
      check_out(1, "pending cleared by reset", 1'b0, '0, 1'b0);

      // R10: acknowledge with no offer must not drop the new pending line.
      lines = 8'h10; ack = 1'b1;
      step();
      lines = '0; ack = 1'b0;
      check_out(10, "stray ack", 1'b0, '0, 1'b0);
      step();
      check_out(10, "line 4 kept pending", 1'b1, 3'd4, 1'b1);

      // R8: done with nothing running leaves the held offer alone.
      done = 1'b1;
      step();
      done = 1'b0;
      check_out(8, "idle done keeps offer", 1'b1, 3'd4, 1'b1);

      // R5: take it, request drops.
      ack = 1'b1;
      step();
      ack = 1'b0;
      check_out(5, "final take", 1'b0, '0, 1'b0);
      step();
      check_out(5, "no stale offer", 1'b0, '0, 1'b0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule